// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates eight prioritised interrupt levels for a small stack-based CPU. Level 7 has the highest priority and level 0 the lowest. Two registers hold one bit per level. The waiting register records requests that have been seen and not yet retired. The in-service register records levels whose handlers have been entered and not yet returned from. The block takes eight already-masked hardware request lines, plus a software request from the CPU that names a level. It samples all of these once per instruction slot, and only in slots that are not I/O transfers.

When a waiting level outranks every level in service, the block raises its request toward the CPU. If the CPU's global enable flag is set on a sampling slot, the block dispatches the best such level. It marks that level in service and issues an acknowledge pulse that carries the level and its handler address, a fixed base plus the level times an eight-word slot. The CPU uses this pulse to perform the short call. A return pulse from the CPU retires the innermost (highest) level in service from both registers. This allows nesting of strictly higher priorities only.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset the waiting and in-service registers read zero, and cpuIrq and ackPulse are low.
- R2: On a clock edge where slotStrobe is high and ioSlot is low, each set bit of the combined request vector is ORed into the waiting register. Requests seen on any other edge are ignored.
- R3: When swReq is high, bit swLevel of the combined request vector is set, in addition to the hardware lines.
- R4: cpuIrq is high exactly when some level is waiting, is not in service, and is numerically above every level in service.
- R5: On an edge where slotStrobe, globalEnable and cpuIrq are all high, the highest level that qualifies under R4 becomes in service. In the next cycle ackPulse is high for one cycle, with ackLevel set to that level and ackVector = VEC_BASE + level*8 (default VEC_BASE = 0x100).
- R6: While globalEnable is low, no dispatch happens but requests are still recorded. Dispatch proceeds on the first sampling slot after the flag is set again.
- R7: A retPulse clears the highest in-service bit in both registers. With nothing in service, it changes neither register.
- R8: A request for a level whose waiting bit is already set leaves the registers unchanged, so that level is serviced only once.
- R9: A request for the level being retired, presented on the same edge as the retPulse, is lost.
- R10: While a level is in service, an equal or lower level is not dispatched, and a higher level is dispatched on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hwReq | input | 8 | Masked hardware request lines, bit n for level n |
| swReq | input | 1 | Software interrupt request from the CPU |
| swLevel | input | 3 | Level addressed by swReq |
| slotStrobe | input | 1 | Marks the sampling point of an instruction slot |
| ioSlot | input | 1 | Current slot is an I/O transfer |
| globalEnable | input | 1 | CPU global interrupt enable flag |
| retPulse | input | 1 | Return-from-interrupt executed |
| cpuIrq | output | 1 | A level eligible for dispatch exists |
| ackPulse | output | 1 | One-cycle dispatch acknowledge |
| ackLevel | output | 3 | Level dispatched |
| ackVector | output | 12 | Handler address of the dispatched level |
| waitingBits | output | 8 | Waiting register |
| inServiceBits | output | 8 | In-service register |

## Verification
The hardest situations to reach are the ones where two events land on the same edge. One is a request for a level arriving exactly as that level is retired. The other is a request repeated for a level that is still in service. Nested states, where a lower level sits waiting underneath a higher level in service, also take care to build. The bench builds these cases with explicit slot-by-slot stimulus, using the global enable as a gate. It first fills the waiting register while dispatch is held off, then releases one dispatch at a time. It presents the return pulse and the conflicting request in a single cycle. It then checks, after each step, that the retired level neither reappears in the registers nor raises cpuIrq.

// File: rtl/nic_pkg.sv
package nic_pkg;

  // Strobes handed from the control module to the datapath each cycle.
  typedef struct packed {
    logic latchEn;     // merge requests into the waiting register
    logic dispatchEn;  // mark the best eligible level in service
    logic retireEn;    // retire the innermost in-service level
  } nicStrobes_t;

endpackage

// File: rtl/nic_prio_enc.sv
// Finds the highest set bit of a vector.
module nic_prio_enc #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/nic_control.sv
// Turns slot timing, enable and return inputs into datapath strobes.
module nic_control
  import nic_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] hwReq,
  input  logic                  swReq,
  input  logic [LVL_W-1:0]      swLevel,
  input  logic                  slotStrobe,
  input  logic                  ioSlot,
  input  logic                  globalEnable,
  input  logic                  retPulse,
  input  logic                  eligibleAny,
  output logic [NUM_LEVELS-1:0] reqVec,
  output nicStrobes_t           strobes
);

  logic [NUM_LEVELS-1:0] swOneHot;

  always_comb begin
    swOneHot = '0;
    if (swReq) swOneHot = NUM_LEVELS'(1) << swLevel;
  end

  assign reqVec = hwReq | swOneHot;

  always_comb begin
    strobes.latchEn    = slotStrobe && !ioSlot;
    strobes.dispatchEn = slotStrobe && globalEnable && eligibleAny;
    strobes.retireEn   = retPulse;
  end

endmodule

// File: rtl/nic_datapath.sv
// Waiting and in-service registers, eligibility logic, vector generation.
module nic_datapath
  import nic_pkg::*;
#(
  parameter int                 NUM_LEVELS = 8,
  parameter int                 LVL_W      = $clog2(NUM_LEVELS),
  parameter int                 ADDR_W     = 12,
  parameter int                 SLOT_SHIFT = 3,
  parameter logic [ADDR_W-1:0]  VEC_BASE   = 12'h100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  nicStrobes_t           strobes,
  input  logic [NUM_LEVELS-1:0] reqVec,
  output logic                  eligibleAny,
  output logic [NUM_LEVELS-1:0] waitingQ,
  output logic [NUM_LEVELS-1:0] inServiceQ,
  output logic                  ackPulseQ,
  output logic [LVL_W-1:0]      ackLevelQ,
  output logic [ADDR_W-1:0]     ackVectorQ
);

  logic [NUM_LEVELS-1:0] aboveAll;
  logic [NUM_LEVELS-1:0] eligible;
  logic [NUM_LEVELS-1:0] clrMask;
  logic [NUM_LEVELS-1:0] setMask;
  logic [NUM_LEVELS-1:0] waitingN;
  logic [NUM_LEVELS-1:0] inServiceN;
  logic                  topFound;
  logic [LVL_W-1:0]      topIdx;
  logic [LVL_W-1:0]      selIdx;

  // A level may nest only above every level currently in service.
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_above
    assign aboveAll[g] = ~|inServiceQ[NUM_LEVELS-1:g];
  end

  assign eligible = waitingQ & ~inServiceQ & aboveAll;

  nic_prio_enc #(.W(NUM_LEVELS), .IDX_W(LVL_W)) u_selEnc (
    .vec   (eligible),
    .found (eligibleAny),
    .idx   (selIdx)
  );

  nic_prio_enc #(.W(NUM_LEVELS), .IDX_W(LVL_W)) u_topEnc (
    .vec   (inServiceQ),
    .found (topFound),
    .idx   (topIdx)
  );

  always_comb begin
    clrMask = '0;
    setMask = '0;
    if (strobes.retireEn && topFound) clrMask = NUM_LEVELS'(1) << topIdx;
    if (strobes.dispatchEn)           setMask = NUM_LEVELS'(1) << selIdx;
    // Requests merge into the register as it stood before the retire,
    // so a request for the level being retired is absorbed and lost.
    waitingN   = (waitingQ | (strobes.latchEn ? reqVec : '0)) & ~clrMask;
    inServiceN = (inServiceQ & ~clrMask) | setMask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waitingQ   <= '0;
      inServiceQ <= '0;
      ackPulseQ  <= 1'b0;
      ackLevelQ  <= '0;
      ackVectorQ <= '0;
    end else begin
      waitingQ   <= waitingN;
      inServiceQ <= inServiceN;
      ackPulseQ  <= strobes.dispatchEn;
      if (strobes.dispatchEn) begin
        ackLevelQ  <= selIdx;
        ackVectorQ <= VEC_BASE + (ADDR_W'(selIdx) << SLOT_SHIFT);
      end
    end
  end

endmodule

// File: rtl/nested_irq_ctrl.sv
// Thin top: control strobes drive the register datapath.
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int                 NUM_LEVELS = 8,
  parameter int                 LVL_W      = $clog2(NUM_LEVELS),
  parameter int                 ADDR_W     = 12,
  parameter int                 SLOT_SHIFT = 3,
  parameter logic [ADDR_W-1:0]  VEC_BASE   = 12'h100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] hwReq,
  input  logic                  swReq,
  input  logic [LVL_W-1:0]      swLevel,
  input  logic                  slotStrobe,
  input  logic                  ioSlot,
  input  logic                  globalEnable,
  input  logic                  retPulse,
  output logic                  cpuIrq,
  output logic                  ackPulse,
  output logic [LVL_W-1:0]      ackLevel,
  output logic [ADDR_W-1:0]     ackVector,
  output logic [NUM_LEVELS-1:0] waitingBits,
  output logic [NUM_LEVELS-1:0] inServiceBits
);

  nicStrobes_t           strobes;
  logic [NUM_LEVELS-1:0] reqVec;
  logic                  eligibleAny;

  nic_control #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_ctrl (
    .hwReq        (hwReq),
    .swReq        (swReq),
    .swLevel      (swLevel),
    .slotStrobe   (slotStrobe),
    .ioSlot       (ioSlot),
    .globalEnable (globalEnable),
    .retPulse     (retPulse),
    .eligibleAny  (eligibleAny),
    .reqVec       (reqVec),
    .strobes      (strobes)
  );

  nic_datapath #(
    .NUM_LEVELS (NUM_LEVELS),
    .LVL_W      (LVL_W),
    .ADDR_W     (ADDR_W),
    .SLOT_SHIFT (SLOT_SHIFT),
    .VEC_BASE   (VEC_BASE)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .reqVec      (reqVec),
    .eligibleAny (eligibleAny),
    .waitingQ    (waitingBits),
    .inServiceQ  (inServiceBits),
    .ackPulseQ   (ackPulse),
    .ackLevelQ   (ackLevel),
    .ackVectorQ  (ackVector)
  );

  assign cpuIrq = eligibleAny;

endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int NUM_LEVELS = 8,
  parameter int LVL_W      = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  slotStrobe,
  input logic                  ioSlot,
  input logic                  globalEnable,
  input logic                  ackPulse,
  input logic [LVL_W-1:0]      ackLevel,
  input logic [NUM_LEVELS-1:0] waitingBits,
  input logic [NUM_LEVELS-1:0] inServiceBits
);

  // New waiting bits appear only after a non-I/O sampling slot.
  assert_latch_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(waitingBits & ~$past(waitingBits))) |-> $past(slotStrobe && !ioSlot));

  // A dispatched level is in service when its acknowledge is visible.
  assert_ack_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ackPulse |-> inServiceBits[ackLevel]);

  // Acknowledge follows only a slot with the global enable set.
  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ackPulse |-> $past(slotStrobe && globalEnable));

  // In-service levels are always still waiting until retired together.
  assert_service_waiting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inServiceBits & ~waitingBits) == '0);

  // The dispatched level is the innermost one: nothing above it in service.
  assert_nest_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ackPulse |-> ((inServiceBits >> ackLevel) == NUM_LEVELS'(1)));

endmodule

bind nested_irq_ctrl nic_checker #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .slotStrobe    (slotStrobe),
  .ioSlot        (ioSlot),
  .globalEnable  (globalEnable),
  .ackPulse      (ackPulse),
  .ackLevel      (ackLevel),
  .waitingBits   (waitingBits),
  .inServiceBits (inServiceBits)
);

// File: tb/nested_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nested_irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  hwReq = '0;
  logic        swReq = 1'b0;
  logic [2:0]  swLevel = '0;
  logic        slotStrobe = 1'b0;
  logic        ioSlot = 1'b0;
  logic        globalEnable = 1'b0;
  logic        retPulse = 1'b0;
  logic        cpuIrq;
  logic        ackPulse;
  logic [2:0]  ackLevel;
  logic [11:0] ackVector;
  logic [7:0]  waitingBits;
  logic [7:0]  inServiceBits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nested_irq_ctrl u_dut (
    .clk (clk), .rst_n (rst_n), .hwReq (hwReq), .swReq (swReq),
    .swLevel (swLevel), .slotStrobe (slotStrobe), .ioSlot (ioSlot),
    .globalEnable (globalEnable), .retPulse (retPulse), .cpuIrq (cpuIrq),
    .ackPulse (ackPulse), .ackLevel (ackLevel), .ackVector (ackVector),
    .waitingBits (waitingBits), .inServiceBits (inServiceBits)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Present one cycle of stimulus at a falling edge; return at the next
  // falling edge, after the rising edge has taken effect.
  task automatic tick(input logic [7:0] req, input logic sw, input logic [2:0] swl,
                      input logic stb, input logic io, input logic ret);
    hwReq = req; swReq = sw; swLevel = swl;
    slotStrobe = stb; ioSlot = io; retPulse = ret;
    @(negedge clk);
    hwReq = '0; swReq = 1'b0; swLevel = '0;
    slotStrobe = 1'b0; ioSlot = 1'b0; retPulse = 1'b0;
  endtask

  task automatic expectAck(input string req, input logic [2:0] lvl);
    chk(req, "ackPulse", 32'(ackPulse), 32'd1);
    chk(req, "ackLevel", 32'(ackLevel), 32'(lvl));
    chk(req, "ackVector", 32'(ackVector), 32'h100 + 32'(lvl) * 8);
  endtask

  task automatic testReset();
    chk("R1", "waiting", 32'(waitingBits), 32'h0);
    chk("R1", "inService", 32'(inServiceBits), 32'h0);
    chk("R1", "cpuIrq", 32'(cpuIrq), 32'd0);
    chk("R1", "ackPulse", 32'(ackPulse), 32'd0);
  endtask

  task automatic testLatchAndGate();
    globalEnable = 1'b0;
    tick(8'h05, 0, 0, 1, 1, 0);            // I/O slot: ignored
    chk("R2", "waiting after io slot", 32'(waitingBits), 32'h0);
    tick(8'h05, 0, 0, 0, 0, 0);            // no strobe: ignored
    chk("R2", "waiting without strobe", 32'(waitingBits), 32'h0);
    tick(8'h05, 0, 0, 1, 0, 0);
    chk("R2", "waiting latched", 32'(waitingBits), 32'h05);
    chk("R4", "cpuIrq with waiting", 32'(cpuIrq), 32'd1);
    tick(8'h00, 0, 0, 1, 0, 0);
    tick(8'h00, 0, 0, 1, 0, 0);
    chk("R6", "no ack while disabled", 32'(ackPulse), 32'd0);
    chk("R6", "nothing in service", 32'(inServiceBits), 32'h0);
    globalEnable = 1'b1;
    tick(8'h00, 0, 0, 1, 0, 0);
    expectAck("R5", 3'd2);
    chk("R5", "level 2 in service", 32'(inServiceBits), 32'h04);
    chk("R10", "cpuIrq low for lower level", 32'(cpuIrq), 32'd0);
    tick(8'h00, 0, 0, 1, 0, 0);
    chk("R5", "ack lasts one cycle", 32'(ackPulse), 32'd0);
    chk("R10", "level 0 not nested", 32'(inServiceBits), 32'h04);
  endtask

  task automatic testRetire();
    tick(8'h00, 0, 0, 0, 0, 1);
    chk("R7", "waiting after retire", 32'(waitingBits), 32'h01);
    chk("R7", "inService after retire", 32'(inServiceBits), 32'h00);
    chk("R4", "cpuIrq after retire", 32'(cpuIrq), 32'd1);
    tick(8'h00, 0, 0, 1, 0, 0);
    expectAck("R5", 3'd0);
    tick(8'h00, 0, 0, 0, 0, 1);
    chk("R7", "all clear", 32'(waitingBits | inServiceBits), 32'h0);
    tick(8'h00, 0, 0, 0, 0, 1);
    chk("R7", "retire with none in service", 32'(waitingBits | inServiceBits), 32'h0);
  endtask

  task automatic testNesting();
    globalEnable = 1'b1;
    tick(8'h08, 0, 0, 1, 0, 0);            // latch level 3
    tick(8'h00, 0, 0, 1, 0, 0);            // dispatch it
    expectAck("R10", 3'd3);
    tick(8'h20, 0, 0, 1, 0, 0);            // level 5 arrives
    tick(8'h00, 0, 0, 1, 0, 0);
    expectAck("R10", 3'd5);
    chk("R10", "3 and 5 in service", 32'(inServiceBits), 32'h28);
    tick(8'h10, 0, 0, 1, 0, 0);            // level 4 under 5
    tick(8'h00, 0, 0, 1, 0, 0);
    chk("R10", "level 4 held", 32'(ackPulse), 32'd0);
    chk("R4", "cpuIrq low under 5", 32'(cpuIrq), 32'd0);
    chk("R10", "waiting 3,4,5", 32'(waitingBits), 32'h38);
    tick(8'h00, 0, 0, 0, 0, 1);            // retire 5
    chk("R7", "5 retired", 32'(inServiceBits), 32'h08);
    chk("R4", "cpuIrq for 4 above 3", 32'(cpuIrq), 32'd1);
    tick(8'h00, 0, 0, 1, 0, 0);
    expectAck("R10", 3'd4);
    tick(8'h00, 0, 0, 0, 0, 1);
    tick(8'h00, 0, 0, 0, 0, 1);
    chk("R7", "nest unwound", 32'(waitingBits | inServiceBits), 32'h0);
  endtask

  task automatic testLost();
    globalEnable = 1'b0;
    tick(8'h40, 0, 0, 1, 0, 0);
    tick(8'h40, 0, 0, 1, 0, 0);
    chk("R8", "double request once", 32'(waitingBits), 32'h40);
    globalEnable = 1'b1;
    tick(8'h00, 0, 0, 1, 0, 0);
    expectAck("R6", 3'd6);
    tick(8'h40, 0, 0, 1, 0, 0);            // repeat while in service
    chk("R8", "registers unchanged", 32'({waitingBits, inServiceBits}), 32'h4040);
    tick(8'h00, 0, 0, 0, 0, 1);
    chk("R8", "no second service", 32'(cpuIrq), 32'd0);
    chk("R8", "waiting empty", 32'(waitingBits), 32'h0);
    tick(8'h02, 0, 0, 1, 0, 0);
    tick(8'h00, 0, 0, 1, 0, 0);
    expectAck("R9", 3'd1);
    tick(8'h02, 0, 0, 1, 0, 1);            // request on retire edge
    chk("R9", "request lost on retire", 32'(waitingBits | inServiceBits), 32'h0);
    chk("R9", "cpuIrq low", 32'(cpuIrq), 32'd0);
  endtask

  task automatic testSoftware();
    globalEnable = 1'b0;
    tick(8'h00, 1, 3'd7, 0, 0, 0);         // no strobe: ignored
    chk("R3", "sw without strobe", 32'(waitingBits), 32'h0);
    tick(8'h01, 1, 3'd2, 1, 0, 0);
    chk("R3", "sw and hw merged", 32'(waitingBits), 32'h05);
    tick(8'h00, 1, 3'd7, 1, 0, 0);
    chk("R3", "sw level 7", 32'(waitingBits), 32'h85);
    globalEnable = 1'b1;
    tick(8'h00, 0, 0, 1, 0, 0);
    expectAck("R3", 3'd7);
    tick(8'h00, 0, 0, 0, 0, 1);
    tick(8'h00, 0, 0, 1, 0, 0);
    expectAck("R5", 3'd2);
    tick(8'h00, 0, 0, 0, 0, 1);
    tick(8'h00, 0, 0, 1, 0, 0);
    expectAck("R5", 3'd0);
    tick(8'h00, 0, 0, 0, 0, 1);
    chk("R7", "sw test clear", 32'(waitingBits | inServiceBits), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testLatchAndGate();
    testRetire();
    testNesting();
    testLost();
    testSoftware();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule